// File: doc/BRIEF.md
# Clock Synthesizer Divider Configuration Loader

This block holds the divider settings of a frequency synthesizer: the feedback multiplier code M (7 bits), the output divider code N (2 bits) and a 3-bit test-select code T. It can take those settings from two sources. The first is a word presented in parallel and captured when a parallel strobe goes high. The second is a 12-bit frame clocked in one bit at a time by a serial clock and committed when a separate serial strobe goes low. The parallel source always wins. While its strobe is low, any serial commit is discarded.

None of the strobes or the serial clock shares the system clock. Each one passes through a two-flop synchronizer, and its edges are detected on the synchronized level. The serial data line is synchronized through the same depth, so that it stays aligned with its clock. A small multiplexer, steered by the held T code, routes one of several internal nodes to a single test output.

Top module: `pll_cfg_loader`

## Requirements
- R1: After reset the outputs are M = 7'h7F, N = 2'b11 and T = 3'b000. The shift register is cleared, so the test output is 0.
- R2: A rising edge of the parallel strobe loads M from par_m_i and N from par_n_i. T is left unchanged.
- R3: Changes on par_m_i or par_n_i while the parallel strobe holds either level, and a falling edge of that strobe, leave the outputs unchanged.
- R4: The 12-bit shift register moves one bit on each rising edge of the serial clock and takes ser_data_i into bit 0. Falling edges of the serial clock do not shift it.
- R5: A falling edge of the serial strobe, while the parallel strobe is high, loads the configuration from the shift register. M comes from bits 6:0, N from bits 8:7 and T from bits 11:9. A frame is therefore sent T first, then N, then M, with each field MSB first.
- R6: A rising edge of the serial strobe leaves the outputs unchanged.
- R7: A falling edge of the serial strobe while the parallel strobe is low is ignored. The earlier values stay in force.
- R8: If a parallel rising edge and a serial falling edge are detected in the same cycle, M and N come from the parallel inputs and T is left unchanged.
- R9: The test output follows T as follows:
  - 3'b000: shift register bit 11
  - 3'b001: ref_clk_i
  - 3'b010: fb_div_i
  - 3'b011: out_div_i
  - 3'b100 to 3'b111: constant 0
- R10: A strobe edge or serial clock edge that is held stable takes effect on the outputs within six system clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| par_load_i | input | 1 | Parallel strobe; a rising edge captures the parallel word |
| par_m_i | input | 7 | Parallel feedback multiplier code |
| par_n_i | input | 2 | Parallel output divider code |
| ser_clk_i | input | 1 | Serial clock; a rising edge shifts |
| ser_data_i | input | 1 | Serial data |
| ser_load_i | input | 1 | Serial strobe; a falling edge commits the frame |
| ref_clk_i | input | 1 | Reference clock node for the test output |
| fb_div_i | input | 1 | Feedback divider output node for the test output |
| out_div_i | input | 1 | Output divider output node for the test output |
| m_o | output | 7 | Held feedback multiplier code |
| n_o | output | 2 | Held output divider code |
| t_o | output | 3 | Held test-select code |
| test_o | output | 1 | Selected test node |

## Verification
A parallel capture and a serial commit can be detected in the same system clock cycle. The bench forces this by dropping the parallel strobe, raising the serial strobe, and then, on a single falling clock edge, raising the parallel strobe and lowering the serial strobe together. Both inputs go through synchronizers of equal depth, so their pulses coincide. The check confirms that M and N hold the parallel word while T keeps its previous value, even though the shift register holds a frame with different fields.

// File: rtl/pll_cfg_pkg.sv
package pll_cfg_pkg;
  localparam int M_W     = 7;
  localparam int N_W     = 2;
  localparam int T_W     = 3;
  localparam int FRAME_W = T_W + N_W + M_W;
  localparam int N_LSB   = M_W;
  localparam int T_LSB   = M_W + N_W;

  typedef enum logic [T_W-1:0] {
    TSEL_SHIFT  = 3'b000,
    TSEL_REF    = 3'b001,
    TSEL_FB     = 3'b010,
    TSEL_OUTDIV = 3'b011
  } tsel_e;

  typedef struct packed {
    logic [M_W-1:0] m;
    logic [N_W-1:0] n;
    logic [T_W-1:0] t;
  } cfg_t;

  localparam cfg_t CFG_RESET = '{m: '1, n: '1, t: '0};
endpackage

// File: rtl/pcl_sync.sv
module pcl_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic level_o
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb chain_d = async_i;
    end else begin : g_many
      always_comb chain_d = {chain_q[STAGES-2:0], async_i};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign level_o = chain_q[STAGES-1];
endmodule

// File: rtl/pcl_edge.sv
module pcl_edge #(
  parameter int STAGES      = 2,
  parameter bit DETECT_RISE = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic level_o,
  output logic pulse_o
);
  logic lvl;
  logic hist_q;

  pcl_sync #(.STAGES(STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (async_i),
    .level_o (lvl)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist_q <= 1'b0;
    else        hist_q <= lvl;
  end

  generate
    if (DETECT_RISE) begin : g_rise
      assign pulse_o = lvl & ~hist_q;
    end else begin : g_fall
      assign pulse_o = ~lvl & hist_q;
    end
  endgenerate

  assign level_o = lvl;

  // R10: each detected edge is a single-cycle pulse
  assert_single_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_o |=> !pulse_o);
  // R10: the pulse agrees with the level it was detected on
  assert_pulse_level_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_o |-> (level_o == DETECT_RISE));
endmodule

// File: rtl/pcl_shifter.sv
module pcl_shifter #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_en,
  input  logic         din,
  output logic [W-1:0] q
);
  logic [W-1:0] sh_q;
  logic [W-1:0] sh_d;

  always_comb begin
    sh_d = sh_q;
    if (shift_en) sh_d = {sh_q[W-2:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign q = sh_q;

  // R4: without a serial clock rising edge the register holds
  assert_hold_noclk_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(q));
  // R4: a shift moves the old bits up by one position
  assert_shift_up_R4: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> (q[W-1:1] == $past(q[W-2:0])));
endmodule

// File: rtl/pcl_cfg_regs.sv
module pcl_cfg_regs
  import pll_cfg_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               par_fire,
  input  logic               par_level,
  input  logic               ser_fire,
  input  logic [M_W-1:0]     par_m,
  input  logic [N_W-1:0]     par_n,
  input  logic [FRAME_W-1:0] frame,
  output cfg_t               cfg_o
);
  cfg_t cfg_q;
  cfg_t cfg_d;
  logic ser_take;
  logic cfg_en;

  assign ser_take = ser_fire & par_level & ~par_fire;
  assign cfg_en   = par_fire | ser_take;

  always_comb begin
    cfg_d = cfg_q;
    if (par_fire) begin
      cfg_d.m = par_m;
      cfg_d.n = par_n;
    end else if (ser_take) begin
      cfg_d.m = frame[M_W-1:0];
      cfg_d.n = frame[N_LSB +: N_W];
      cfg_d.t = frame[T_LSB +: T_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= CFG_RESET;
    else if (cfg_en) cfg_q <= cfg_d;
  end

  assign cfg_o = cfg_q;

  // R2: a parallel capture loads M and N and keeps T
  assert_par_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
    par_fire |=> (cfg_o.m == $past(par_m)) && (cfg_o.n == $past(par_n))
                 && (cfg_o.t == $past(cfg_o.t)));
  // R5: a serial commit with the parallel strobe high takes the frame
  assert_ser_commit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_fire && par_level && !par_fire) |=> (cfg_o == {$past(frame[M_W-1:0]),
      $past(frame[N_LSB +: N_W]), $past(frame[T_LSB +: T_W])}));
  // R7: a serial commit with the parallel strobe low changes nothing
  assert_ser_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_fire && !par_level && !par_fire) |=> $stable(cfg_o));
  // R3, R6: without a load event the configuration holds
  assert_cfg_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!par_fire && !ser_fire) |=> $stable(cfg_o));
  // R8: a collision keeps T, i.e. the parallel path wins
  assert_par_priority_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (par_fire && ser_fire) |=> (cfg_o.t == $past(cfg_o.t)));
endmodule

// File: rtl/pcl_test_mux.sv
module pcl_test_mux
  import pll_cfg_pkg::*;
(
  input  logic [T_W-1:0] tsel_i,
  input  logic           shift_out_i,
  input  logic           ref_i,
  input  logic           fb_i,
  input  logic           od_i,
  output logic           test_o
);
  always_comb begin
    case (tsel_e'(tsel_i))
      TSEL_SHIFT:  test_o = shift_out_i;
      TSEL_REF:    test_o = ref_i;
      TSEL_FB:     test_o = fb_i;
      TSEL_OUTDIV: test_o = od_i;
      default:     test_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/pll_cfg_loader.sv
module pll_cfg_loader
  import pll_cfg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           par_load_i,
  input  logic [M_W-1:0] par_m_i,
  input  logic [N_W-1:0] par_n_i,
  input  logic           ser_clk_i,
  input  logic           ser_data_i,
  input  logic           ser_load_i,
  input  logic           ref_clk_i,
  input  logic           fb_div_i,
  input  logic           out_div_i,
  output logic [M_W-1:0] m_o,
  output logic [N_W-1:0] n_o,
  output logic [T_W-1:0] t_o,
  output logic           test_o
);
  logic [1:0]         rst_sync_q;
  logic               rst_n_s;
  logic               par_lvl;
  logic               par_rise;
  logic               sclk_lvl;
  logic               sclk_rise;
  logic               sld_lvl;
  logic               sld_fall;
  logic               sdata_s;
  logic [FRAME_W-1:0] frame;
  cfg_t               cfg;
  logic               unused_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  pcl_edge #(.STAGES(SYNC_STAGES), .DETECT_RISE(1'b1)) u_par_edge (
    .clk (clk), .rst_n (rst_n_s), .async_i (par_load_i),
    .level_o (par_lvl), .pulse_o (par_rise)
  );

  pcl_edge #(.STAGES(SYNC_STAGES), .DETECT_RISE(1'b1)) u_sclk_edge (
    .clk (clk), .rst_n (rst_n_s), .async_i (ser_clk_i),
    .level_o (sclk_lvl), .pulse_o (sclk_rise)
  );

  pcl_edge #(.STAGES(SYNC_STAGES), .DETECT_RISE(1'b0)) u_sld_edge (
    .clk (clk), .rst_n (rst_n_s), .async_i (ser_load_i),
    .level_o (sld_lvl), .pulse_o (sld_fall)
  );

  pcl_sync #(.STAGES(SYNC_STAGES)) u_sdata_sync (
    .clk (clk), .rst_n (rst_n_s), .async_i (ser_data_i), .level_o (sdata_s)
  );

  pcl_shifter #(.W(FRAME_W)) u_shifter (
    .clk (clk), .rst_n (rst_n_s), .shift_en (sclk_rise),
    .din (sdata_s), .q (frame)
  );

  pcl_cfg_regs u_cfg (
    .clk (clk), .rst_n (rst_n_s),
    .par_fire (par_rise), .par_level (par_lvl), .ser_fire (sld_fall),
    .par_m (par_m_i), .par_n (par_n_i), .frame (frame), .cfg_o (cfg)
  );

  pcl_test_mux u_tmux (
    .tsel_i (cfg.t), .shift_out_i (frame[FRAME_W-1]),
    .ref_i (ref_clk_i), .fb_i (fb_div_i), .od_i (out_div_i),
    .test_o (test_o)
  );

  assign m_o = cfg.m;
  assign n_o = cfg.n;
  assign t_o = cfg.t;

  assign unused_ok = &{1'b0, sclk_lvl, sld_lvl};

  // R9: unassigned select codes drive a constant low
  assert_unused_codes_low_R9: assert property (@(posedge clk) disable iff (!rst_n_s)
    (t_o[T_W-1]) |-> !test_o);
  // R1: right after reset the defaults are in place
  assert_reset_defaults_R1: assert property (@(posedge clk)
    !rst_n_s |=> (m_o == '1) && (n_o == '1) && (t_o == '0));
endmodule

// File: tb/pll_cfg_loader_tb.sv
module pll_cfg_loader_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       par_load_i, ser_clk_i, ser_data_i, ser_load_i;
  logic [6:0] par_m_i;
  logic [1:0] par_n_i;
  logic       ref_clk_i, fb_div_i, out_div_i;
  logic [6:0] m_o;
  logic [1:0] n_o;
  logic [2:0] t_o;
  logic       test_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  logic [6:0]  exp_m;
  logic [1:0]  exp_n;
  logic [2:0]  exp_t;
  logic [11:0] exp_sh;

  always #4 clk = ~clk;

  pll_cfg_loader u_dut (
    .clk (clk), .rst_n (rst_n),
    .par_load_i (par_load_i), .par_m_i (par_m_i), .par_n_i (par_n_i),
    .ser_clk_i (ser_clk_i), .ser_data_i (ser_data_i), .ser_load_i (ser_load_i),
    .ref_clk_i (ref_clk_i), .fb_div_i (fb_div_i), .out_div_i (out_div_i),
    .m_o (m_o), .n_o (n_o), .t_o (t_o), .test_o (test_o)
  );

  function automatic logic tmux_exp(logic [2:0] t, logic [11:0] sh,
                                    logic r, logic f, logic o);
    case (t)
      3'd0:    return sh[11];
      3'd1:    return r;
      3'd2:    return f;
      3'd3:    return o;
      default: return 1'b0;
    endcase
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic check_all(string req);
    chk(req, {25'd0, m_o}, {25'd0, exp_m});
    chk(req, {30'd0, n_o}, {30'd0, exp_n});
    chk(req, {29'd0, t_o}, {29'd0, exp_t});
    chk(req, {31'd0, test_o},
        {31'd0, tmux_exp(exp_t, exp_sh, ref_clk_i, fb_div_i, out_div_i)});
  endtask

  task automatic wait_n(int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic par_capture(logic [6:0] m, logic [1:0] n);
    par_load_i = 1'b0;
    wait_n(6);
    par_m_i = m;
    par_n_i = n;
    wait_n(2);
    par_load_i = 1'b1;
    wait_n(6);
    exp_m = m;
    exp_n = n;
  endtask

  task automatic ser_bit(logic b);
    ser_data_i = b;
    wait_n(3);
    ser_clk_i = 1'b1;
    wait_n(3);
    ser_clk_i = 1'b0;
    wait_n(3);
    exp_sh = {exp_sh[10:0], b};
  endtask

  task automatic ser_frame(logic [2:0] t, logic [1:0] n, logic [6:0] m);
    logic [11:0] f;
    f = {t, n, m};
    for (int i = 11; i >= 0; i--) ser_bit(f[i]);
  endtask

  task automatic ser_commit(bit check_rise);
    ser_load_i = 1'b1;
    wait_n(6);
    if (check_rise) check_all("R6 serial strobe rise no effect");
    ser_load_i = 1'b0;
    wait_n(6);
    if (par_load_i) begin
      exp_m = exp_sh[6:0];
      exp_n = exp_sh[8:7];
      exp_t = exp_sh[11:9];
    end
  endtask

  task automatic finish_run;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      finish_run();
    end
  end

  initial begin
    logic [11:0] f;
    void'($urandom(32'd2718));
    rst_n = 1'b0;
    par_load_i = 1'b0; par_m_i = 7'h00; par_n_i = 2'b00;
    ser_clk_i = 1'b0; ser_data_i = 1'b0; ser_load_i = 1'b0;
    ref_clk_i = 1'b0; fb_div_i = 1'b0; out_div_i = 1'b0;
    exp_m = 7'h7F; exp_n = 2'b11; exp_t = 3'b000; exp_sh = 12'h000;
    wait_n(5);
    rst_n = 1'b1;
    wait_n(5);
    check_all("R1 reset defaults");

    // R2: parallel capture
    par_capture(7'h25, 2'b01);
    check_all("R2 parallel capture");

    // R3: inputs change while the strobe is high
    par_m_i = 7'h5A; par_n_i = 2'b10;
    wait_n(8);
    check_all("R3 parallel inputs held high");

    // R4: shift a frame with T=0 so the test output shows bit 11
    ser_frame(3'b000, 2'b10, 7'h33);
    chk("R4 shift register top bit", {31'd0, test_o}, {31'd0, exp_sh[11]});
    ser_bit(1'b1);
    chk("R4 one more shift", {31'd0, test_o}, {31'd0, exp_sh[11]});

    // R5 and R6: full serial load
    ser_frame(3'b010, 2'b00, 7'h4C);
    ser_commit(1'b1);
    check_all("R5 serial commit");
    chk("R5 field M", {25'd0, m_o}, 32'h4C);
    chk("R5 field T", {29'd0, t_o}, 32'h2);

    // R3: falling parallel strobe does nothing; R7: serial ignored while low
    par_load_i = 1'b0;
    wait_n(8);
    check_all("R3 parallel strobe fall no effect");
    ser_frame(3'b001, 2'b11, 7'h11);
    ser_commit(1'b0);
    check_all("R7 serial commit while parallel low");

    // R8: collision, parallel strobe still low here
    ser_frame(3'b011, 2'b01, 7'h0F);
    ser_load_i = 1'b1;
    par_m_i = 7'h62; par_n_i = 2'b10;
    wait_n(6);
    par_load_i = 1'b1;
    ser_load_i = 1'b0;
    wait_n(6);
    exp_m = 7'h62; exp_n = 2'b10;
    check_all("R8 same-cycle priority");

    // R9: directed mux codes
    for (int c = 0; c < 8; c++) begin
      ser_frame(c[2:0], exp_n, exp_m);
      ser_commit(1'b0);
      ref_clk_i = 1'b1; fb_div_i = 1'b0; out_div_i = 1'b1;
      wait_n(1);
      check_all("R9 test mux code");
      ref_clk_i = 1'b0; fb_div_i = 1'b1; out_div_i = 1'b0;
      wait_n(1);
      check_all("R9 test mux code inverted");
    end

    // R10: random mix of loads and mux observations
    for (int it = 0; it < 40; it++) begin
      case ($urandom % 3)
        0: par_capture(7'($urandom), 2'($urandom));
        1: begin
          f = 12'($urandom);
          ser_frame(f[11:9], f[8:7], f[6:0]);
          ser_commit(1'b0);
        end
        default: begin
          ref_clk_i = 1'($urandom);
          fb_div_i  = 1'($urandom);
          out_div_i = 1'($urandom);
          wait_n(1);
        end
      endcase
      check_all("R10 random sequence");
    end

    done = 1'b1;
    finish_run();
  end
endmodule